// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver

This block receives one byte at a time over a clocked serial link. It can drive the transfer clock itself, derived from the system clock, or it can follow a clock supplied by the remote device. A transfer does not start on its own. Software first sets both enable bits in the control register. It then writes any value to the transmit-buffer address. That dummy write arms one byte.

On every rising edge of the transfer clock, the block takes one data bit into a shift register. The bit order is selectable. After the eighth bit, the assembled byte moves into the receive buffer. The internally generated clock then halts at the high level. A completion flag and an interrupt request both go high. A read of the receive buffer drops the completion flag, and the interrupt request stays set until software clears it explicitly.

Software reaches the block through a small word-addressed register port. Address 0 is control. Address 1 is the transmit-buffer trigger (write only, reads 0). Address 2 is the received byte. Address 3 is status: bit 0 is the completion flag and bit 1 is the interrupt request. The control bits are: bit 0 receive enable, bit 1 transmit enable, bits 3:2 clock source, bit 4 external clock, bit 5 MSB-first. Bits 7:6 are stored and read back with no effect.

Top module: `csync_rx`

## Requirements
- R1: After reset, control, status and received byte all read 0, and the transfer clock output is high.
- R2: A write to address 1 starts a byte only if control bits 0 and 1 are both 1. Otherwise it has no effect: the clock output stays high and status stays 0.
- R3: With control bit 4 clear, the transfer clock toggles once per source tick, and the first toggle after arming goes low. Source code 0 gives a tick every system cycle, code 1 every 8th cycle, code 2 every 32nd cycle, and code 3 one tick per pulse on `alt_tick_i`. The divide counters start from the arming write.
- R4: With control bit 5 clear (LSB first), each sampled bit enters bit 7 and the register shifts right, so the first received bit ends in bit 0.
- R5: With control bit 5 set (MSB first), each sampled bit enters bit 0 and the register shifts left, so the first received bit ends in bit 7.
- R6: On the eighth rising edge, the byte is copied to address 2. The transfer stops and the clock output stays high until the next arming write.
- R7: Completion of a byte sets status bit 0 and status bit 1, and `irq_o` follows status bit 1.
- R8: A read of address 2 clears status bit 0 and leaves status bit 1 unchanged.
- R9: Status bit 1 clears only on a write to address 3 with data bit 1 equal to 0. Writing 1 there leaves it set.
- R10: With control bit 4 set, clock and data inputs pass through two-flop synchronizers. Data is sampled on synchronized rising edges of `ext_clk_i`, edges while no byte is armed are ignored, and `sclk_o` stays high.
- R11: A write to address 1 while a byte is in progress is ignored, and the byte in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| alt_tick_i | input | 1 | One-cycle tick from the alternate slow clock source |
| ext_clk_i | input | 1 | Transfer clock from the remote device |
| rxd_i | input | 1 | Serial data input |
| sclk_o | output | 1 | Internally generated transfer clock, idles high |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach is the external-clock mode. There, the moment of sampling depends on a synchronizer pipeline and an edge detector, both hidden from the ports. A bit change that lands next to a clock rise could be taken a cycle early or late. The bench drives the remote clock with slow, multi-cycle phases and holds data steady around each rise. It also toggles the clock while nothing is armed, to show those edges are dropped. A second reachable-only-by-timing case is a re-arming write issued in the middle of a divided-clock transfer.

// File: rtl/csync_pkg.sv
package csync_pkg;
  typedef enum logic [1:0] {
    SRC_DIV1 = 2'd0,
    SRC_DIVA = 2'd1,
    SRC_DIVB = 2'd2,
    SRC_ALT  = 2'd3
  } src_sel_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TXB  = 2'd1;
  localparam logic [1:0] ADDR_RXB  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CB_RXEN = 0;
  localparam int CB_TXEN = 1;
  localparam int CB_SRC  = 2;
  localparam int CB_EXT  = 4;
  localparam int CB_MSB  = 5;
endpackage

// File: rtl/csync_clkgen.sv
module csync_clkgen
  import csync_pkg::*;
#(
  parameter int DIV_A      = 8,
  parameter int DIV_B      = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_ni,
  input  logic     arm_i,
  input  logic     run_i,
  input  logic     ext_mode_i,
  input  src_sel_e src_sel_i,
  input  logic     alt_tick_i,
  input  logic     ext_clk_i,
  input  logic     rxd_i,
  output logic     sample_o,
  output logic     bit_o,
  output logic     sclk_o
);
  localparam int PW = $clog2(DIV_B);
  localparam int AW = $clog2(DIV_A);

  logic [PW-1:0]         presc_q, presc_d;
  logic                  sclk_q, sclk_d;
  logic [SYNC_DEPTH-1:0] ck_sync_q, rx_sync_q;
  logic                  ck_prev_q;
  logic                  src_tick, int_tick, ck_rise;

  // source tick selection
  always_comb begin
    unique case (src_sel_i)
      SRC_DIV1: src_tick = 1'b1;
      SRC_DIVA: src_tick = (presc_q[AW-1:0] == {AW{1'b1}});
      SRC_DIVB: src_tick = (presc_q == {PW{1'b1}});
      default:  src_tick = alt_tick_i;
    endcase
  end

  assign int_tick = run_i && !ext_mode_i && src_tick;
  assign ck_rise  = ck_sync_q[SYNC_DEPTH-1] && !ck_prev_q;
  assign sample_o = (int_tick && !sclk_q) || (run_i && ext_mode_i && ck_rise);
  assign bit_o    = ext_mode_i ? rx_sync_q[SYNC_DEPTH-1] : rxd_i;
  assign sclk_o   = sclk_q;

  always_comb begin
    presc_d = presc_q;
    if (arm_i)      presc_d = '0;
    else if (run_i) presc_d = presc_q + 1'b1;
    else            presc_d = '0;
  end

  always_comb begin
    sclk_d = sclk_q;
    if (arm_i || !run_i || ext_mode_i) sclk_d = 1'b1;
    else if (int_tick)                 sclk_d = !sclk_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      sclk_q  <= 1'b1;
    end else begin
      presc_q <= presc_d;
      sclk_q  <= sclk_d;
    end
  end

  // synchronizer chains, depth picked by parameter
  generate
    if (SYNC_DEPTH > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
          ck_sync_q <= '0;
          rx_sync_q <= '0;
        end else begin
          ck_sync_q <= {ck_sync_q[SYNC_DEPTH-2:0], ext_clk_i};
          rx_sync_q <= {rx_sync_q[SYNC_DEPTH-2:0], rxd_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
          ck_sync_q <= '0;
          rx_sync_q <= '0;
        end else begin
          ck_sync_q <= ext_clk_i;
          rx_sync_q <= rxd_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ck_prev_q <= 1'b0;
    else         ck_prev_q <= ck_sync_q[SYNC_DEPTH-1];
  end

  // R6: clock rests high whenever no byte is in progress
  assert_sclk_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !run_i |-> sclk_o);
  // R10: external mode keeps the internal clock output high
  assert_ext_sclk_high_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (ext_mode_i && $past(ext_mode_i)) |-> sclk_o);
  // R3: a falling clock output is always caused by a tick during a run
  assert_fall_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(sclk_o) |-> $past(run_i && !ext_mode_i));
endmodule

// File: rtl/csync_shift.sv
module csync_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          sample_i,
  input  logic          bit_i,
  input  logic          msb_first_i,
  output logic          complete_o,
  output logic [DW-1:0] byte_o
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sh_q, sh_d, shifted;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (msb_first_i) shifted = {sh_q[DW-2:0], bit_i};
    else             shifted = {bit_i, sh_q[DW-1:1]};
  end

  assign complete_o = sample_i && (cnt_q == CW'(DW - 1));
  assign byte_o     = shifted;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (arm_i) begin
      cnt_d = '0;
    end else if (sample_i) begin
      sh_d  = shifted;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // R6: a completion pulse restarts the bit count
  assert_count_wraps_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (complete_o && !arm_i) |=> (cnt_q == '0));
endmodule

// File: rtl/csync_rx.sv
module csync_rx
  import csync_pkg::*;
#(
  parameter int DW         = 8,
  parameter int DIV_A      = 8,
  parameter int DIV_B      = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          alt_tick_i,
  input  logic          ext_clk_i,
  input  logic          rxd_i,
  output logic          sclk_o,
  output logic          irq_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic [DW-1:0] ctrl_q, ctrl_d, rxbuf_q, rxbuf_d, byte_nxt;
  logic          busy_q, busy_d, done_q, done_d, irq_q, irq_d;
  logic          arm, sample, sbit, complete;
  logic          wr_ctrl, wr_txb, rd_rxb, wr_stat;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_txb  = bus_wr && (bus_addr == ADDR_TXB);
  assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
  assign rd_rxb  = bus_rd && (bus_addr == ADDR_RXB);
  assign arm     = wr_txb && ctrl_q[CB_RXEN] && ctrl_q[CB_TXEN] && !busy_q;

  csync_clkgen #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .SYNC_DEPTH(SYNC_DEPTH)
  ) u_clkgen (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .arm_i      (arm),
    .run_i      (busy_q),
    .ext_mode_i (ctrl_q[CB_EXT]),
    .src_sel_i  (src_sel_e'(ctrl_q[CB_SRC+1:CB_SRC])),
    .alt_tick_i (alt_tick_i),
    .ext_clk_i  (ext_clk_i),
    .rxd_i      (rxd_i),
    .sample_o   (sample),
    .bit_o      (sbit),
    .sclk_o     (sclk_o)
  );

  csync_shift #(.DW(DW)) u_shift (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .arm_i       (arm),
    .sample_i    (sample),
    .bit_i       (sbit),
    .msb_first_i (ctrl_q[CB_MSB]),
    .complete_o  (complete),
    .byte_o      (byte_nxt)
  );

  always_comb begin
    ctrl_d  = ctrl_q;
    busy_d  = busy_q;
    rxbuf_d = rxbuf_q;
    done_d  = done_q;
    irq_d   = irq_q;
    if (wr_ctrl) ctrl_d = bus_wdata;
    if (arm)           busy_d = 1'b1;
    else if (complete) busy_d = 1'b0;
    if (complete) begin
      rxbuf_d = byte_nxt;
      done_d  = 1'b1;
      irq_d   = 1'b1;
    end else begin
      if (rd_rxb)                done_d = 1'b0;
      if (wr_stat && !bus_wdata[1]) irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      busy_q  <= 1'b0;
      rxbuf_q <= '0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      busy_q  <= busy_d;
      rxbuf_q <= rxbuf_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = ctrl_q;
      ADDR_RXB:  bus_rdata = rxbuf_q;
      ADDR_STAT: bus_rdata = {{(DW-2){1'b0}}, irq_q, done_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign irq_o = irq_q;

  // R2: a transfer begins only after a trigger write with both enables
  assert_arm_needs_enables_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(wr_txb && ctrl_q[CB_RXEN] && ctrl_q[CB_TXEN]));
  // R7: completion flag and interrupt request rise together
  assert_done_with_irq_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(done_q) |-> irq_q);
  // R8: completion flag drops only after a buffer read
  assert_done_clear_by_read_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(done_q) |-> $past(bus_rd && bus_addr == ADDR_RXB));
  // R9: interrupt request drops only on a status write of 0 in bit 1
  assert_irq_clear_by_write_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(irq_q) |-> $past(bus_wr && bus_addr == ADDR_STAT && !bus_wdata[1]));
  // R6: buffer changes only together with the end of a transfer
  assert_buffer_on_finish_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(rxbuf_q) |-> $fell(busy_q));
endmodule

// File: tb/test_csync_rx.sv
module test_csync_rx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       alt_tick_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       rxd_i;
  logic       sclk_o, irq_o;

  logic       use_ext = 1'b0;
  logic       ext_rxd = 1'b0;
  logic       sl_rxd = 1'b0;
  assign rxd_i = use_ext ? ext_rxd : sl_rxd;

  int vectors = 0;
  int fails = 0;
  bit checking = 1'b0;

  csync_rx i_csync_rx (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alt_tick_i(alt_tick_i), .ext_clk_i(ext_clk_i), .rxd_i(rxd_i),
    .sclk_o(sclk_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // alternate slow source: one pulse every 5 cycles
  int alt_cnt = 0;
  always @(negedge clk) begin
    alt_cnt = (alt_cnt == 4) ? 0 : alt_cnt + 1;
    alt_tick_i = (alt_cnt == 4);
  end

  // remote device for internal clock mode: new bit after each falling clock
  bit sl_on = 1'b0;
  bit sl_prev = 1'b1;
  bit sl_bits[8];
  int sl_idx = 0;
  always @(negedge clk) begin
    if (sl_on && sl_prev && !sclk_o && sl_idx < 8) begin
      sl_rxd = sl_bits[sl_idx];
      sl_idx++;
    end
    sl_prev = sclk_o;
  end

  // behavioural reference for clock output and interrupt line
  int m_ctrl, m_k, m_cnt;
  bit m_busy, m_sclk, m_irq;
  bit c1, c2, c3, d1, d2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_k = 0; m_cnt = 0;
      m_busy = 0; m_sclk = 1; m_irq = 0;
      c1 = 0; c2 = 0; c3 = 0; d1 = 0; d2 = 0;
    end else begin
      bit ext, tick, samp, arm, fin;
      int src;
      ext = m_ctrl[4];
      src = (m_ctrl >> 2) & 3;
      case (src)
        0: tick = 1;
        1: tick = (m_k % 8) == 7;
        2: tick = (m_k % 32) == 31;
        default: tick = alt_tick_i;
      endcase
      tick = tick && m_busy && !ext;
      samp = (tick && !m_sclk) || (m_busy && ext && c2 && !c3);
      arm  = bus_wr && bus_addr == 2'd1 && m_ctrl[0] && m_ctrl[1] && !m_busy;
      fin  = samp && m_cnt == 7;
      if (arm || !m_busy || ext) m_sclk = 1;
      else if (tick)             m_sclk = !m_sclk;
      m_k = arm ? 0 : (m_busy ? m_k + 1 : 0);
      if (arm) m_cnt = 0; else if (samp) m_cnt = (m_cnt + 1) % 8;
      if (arm) m_busy = 1; else if (fin) m_busy = 0;
      if (fin) m_irq = 1;
      else if (bus_wr && bus_addr == 2'd3 && !bus_wdata[1]) m_irq = 0;
      if (bus_wr && bus_addr == 2'd0) m_ctrl = bus_wdata;
      c3 = c2; c2 = c1; c1 = ext_clk_i;
      d2 = d1; d1 = rxd_i;
    end
  end

  // every-cycle comparison (R3 R6 R7 R9 R10 R11)
  always @(negedge clk) begin
    if (checking) begin
      vectors++;
      if (sclk_o !== m_sclk || irq_o !== m_irq) begin
        fails++;
        $display("FAIL R3 R6 R7 R10 cycle compare t=%0t: sclk=%0b irq=%0b expected sclk=%0b irq=%0b",
                 $time, sclk_o, irq_o, m_sclk, m_irq);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    vectors++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s: addr %0d read 0x%02h expected 0x%02h", tag, a, bus_rdata, exp);
    end
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wait_irq(input int limit, input string tag);
    int n = 0;
    while (!irq_o && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk_bit(irq_o, 1'b1, tag);
  endtask

  task automatic load_slave(input logic [7:0] b, input bit msb);
    for (int i = 0; i < 8; i++) sl_bits[i] = msb ? b[7-i] : b[i];
    sl_idx = 0;
    sl_on = 1'b1;
  endtask

  task automatic finish_byte(input logic [7:0] b, input string tag);
    rd_chk(2'd3, 8'h03, "R7 flags after byte");
    rd_chk(2'd2, b, tag);
    rd_chk(2'd3, 8'h02, "R8 read clears done only");
    wr(2'd3, 8'h02);
    rd_chk(2'd3, 8'h02, "R9 writing 1 keeps irq");
    wr(2'd3, 8'h00);
    rd_chk(2'd3, 8'h00, "R9 writing 0 clears irq");
    sl_on = 1'b0;
  endtask

  task automatic int_byte(input logic [7:0] ctrl, input logic [7:0] b, input string tag);
    wr(2'd0, ctrl);
    load_slave(b, ctrl[5]);
    wr(2'd1, 8'hFF);
    wait_irq(1200, "R6 byte completes");
    finish_byte(b, tag);
  endtask

  task automatic ext_bit(input bit b);
    ext_rxd = b;
    ext_clk_i = 1'b0;
    repeat (4) @(negedge clk);
    ext_clk_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic ext_byte(input logic [7:0] ctrl, input logic [7:0] b, input string tag);
    wr(2'd0, ctrl);
    wr(2'd1, 8'h00);
    for (int i = 0; i < 8; i++) ext_bit(ctrl[5] ? b[7-i] : b[i]);
    repeat (4) @(negedge clk);
    chk_bit(irq_o, 1'b1, "R10 external byte completes");
    finish_byte(b, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checking = 1'b1;

    // R1 reset state
    chk_bit(sclk_o, 1'b1, "R1 clock idle high");
    rd_chk(2'd0, 8'h00, "R1 control after reset");
    rd_chk(2'd3, 8'h00, "R1 status after reset");
    rd_chk(2'd2, 8'h00, "R1 buffer after reset");

    // R2 trigger without both enables is ignored
    wr(2'd0, 8'h01);
    wr(2'd1, 8'hAA);
    repeat (40) @(negedge clk);
    chk_bit(sclk_o, 1'b1, "R2 no transfer with transmit enable clear");
    rd_chk(2'd3, 8'h00, "R2 status unchanged");
    wr(2'd0, 8'h02);
    wr(2'd1, 8'hAA);
    repeat (40) @(negedge clk);
    rd_chk(2'd3, 8'h00, "R2 status unchanged receive enable clear");
    rd_chk(2'd0, 8'h02, "R2 control readback");

    // internal sources, both bit orders
    int_byte(8'h03, 8'hA5, "R4 R3 divide-1 LSB first");
    int_byte(8'h27, 8'h5C, "R5 R3 divide-8 MSB first");
    int_byte(8'h0B, 8'h3C, "R4 R3 divide-32 LSB first");
    int_byte(8'h2F, 8'h81, "R5 R3 alternate source MSB first");
    int_byte(8'h03, 8'h00, "R4 all-zero byte");
    int_byte(8'h23, 8'hFF, "R5 all-one byte");

    // R11 re-trigger during a transfer
    wr(2'd0, 8'h07);
    load_slave(8'h96, 1'b0);
    wr(2'd1, 8'h00);
    repeat (40) @(negedge clk);
    wr(2'd1, 8'h00);
    wait_irq(1200, "R11 byte completes after re-trigger");
    finish_byte(8'h96, "R11 byte unchanged by re-trigger");

    // R10 external clock: idle edges ignored, then two bytes
    use_ext = 1'b1;
    wr(2'd0, 8'h13);
    for (int i = 0; i < 5; i++) ext_bit(i[0]);
    rd_chk(2'd3, 8'h00, "R10 idle edges ignored");
    rd_chk(2'd2, 8'h96, "R10 buffer unchanged by idle edges");
    ext_byte(8'h13, 8'hC3, "R10 R4 external LSB first");
    ext_byte(8'h33, 8'h1E, "R10 R5 external MSB first");

    repeat (10) @(negedge clk);
    checking = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule